// File: doc/BRIEF.md
# Alternating Push-Pull Gate Sequencer

This block generates the two gate-drive commands of a push-pull primary stage. A period counter stands in for the oscillator. Each period has a charge phase followed by a discharge phase, and each phase lasts a programmable number of system clocks. A toggle decides which of the two outputs may conduct during a charge phase. The two outputs therefore take turns, and each one runs at half the period rate. The discharge phase is the dead time between the two outputs. A sync output is high for exactly that phase, so that a downstream controller can lock onto the power stage.

A soft-start level controls the pulse width by moving the turn-on point later inside the charge phase. Every pulse ends where discharge begins. A separate fault and retry controller drives the enable input, and dropping enable stops everything. The over-current flag blanks both gates at once, with no wait for a register stage. A one-cycle period tick tells the sequencer each time a new period begins.

Top module: `pp_gate_seq`

## Requirements
- R1: Pulses alternate strictly between outputs. Periods are numbered from 0 after enable. Even periods may drive only `gate_a_o` and odd periods only `gate_b_o`, so the first pulse after enable is on A. The two gates are never high together.
- R2: Neither gate is high during the discharge phase.
- R3: While enabled, `sync_o` is high exactly during the discharge phase and low during the charge phase.
- R4: The block is disabled in the cycle after a clock edge that samples `en_i` low. While disabled, both gates, `sync_o` and `period_end_o` are low. The next clock edge that samples `en_i` high starts period 0 at charge count 0.
- R5: Let C be the charge length, k the charge count (0..C-1) and s the soft-start level. For s from 1 to 7, the gate is high in charge cycles with k >= ((7-s)*C)>>3. The pulse ends when discharge begins, and s=7 gives a full charge-phase pulse.
- R6: A soft-start level of 0 produces no gate pulse, but the periods and `sync_o` keep running.
- R7: When `oc_i` is high, both gates are low in the same cycle, through combinational logic only. Dropping `oc_i` releases the gates without disturbing the period.
- R8: The charge length, the discharge length and the soft-start level are sampled at the start of each period. Changes made mid-period take effect in the next period. A length of 0 is treated as 1.
- R9: `period_end_o` is high for one cycle, in the first charge cycle of every period except period 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable from the fault/retry controller |
| oc_i | input | 1 | Over-current flag; blanks both gates immediately |
| ss_lvl_i | input | SS_W | Soft-start level, 0 (off) to 7 (full) |
| chg_len_i | input | CNT_W | Charge phase length in clocks |
| dis_len_i | input | CNT_W | Discharge (dead-time) length in clocks |
| gate_a_o | output | 1 | Gate command A |
| gate_b_o | output | 1 | Gate command B |
| sync_o | output | 1 | High during the discharge phase while enabled |
| period_end_o | output | 1 | One-cycle tick at each discharge-to-charge transition |

## Verification
The assertions check, on every cycle, the properties that relate signals within a cycle or across a single edge. The gates never overlap, no gate is high while sync is high, over-current blanks the gates, everything is quiet after a disabled edge, and the period tick follows a sync pulse. Some behaviours depend on period counting and on values sampled at period starts, and only the bench's scenarios can show them. These are strict A/B alternation starting on A, the exact turn-on point for each soft-start level, sampling of the lengths at period boundaries and the clamp of zero lengths. The bench sweeps charge lengths 0 to 4, discharge lengths 0 to 3 and all eight levels against an arithmetic period model.

// File: rtl/pp_gate_seq_pkg.sv
package pp_gate_seq_pkg;
  typedef enum logic {
    PH_CHG = 1'b0,
    PH_DIS = 1'b1
  } phase_e;
endpackage

// File: rtl/pp_period_ctr.sv
module pp_period_ctr
  import pp_gate_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SS_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SS_W-1:0]  ss_lvl_i,
  input  logic [CNT_W-1:0] chg_len_i,
  input  logic [CNT_W-1:0] dis_len_i,
  output logic             run_o,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] dly_o,
  output logic             ss_on_o,
  output logic             wrap_o,
  output logic             pend_o
);
  localparam int PW = CNT_W + SS_W;
  localparam logic [SS_W-1:0] SS_MAX = {SS_W{1'b1}};

  logic             run_q, pend_q;
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q, chg_q, dis_q, dly_q;
  logic [SS_W-1:0]  ss_q;

  logic [CNT_W-1:0] chg_eff, dis_eff, dly_nxt;
  logic [PW-1:0]    prod;
  logic             chg_last, dis_last;

  // zero lengths clamp to one clock
  assign chg_eff = (chg_len_i == '0) ? CNT_W'(1) : chg_len_i;
  assign dis_eff = (dis_len_i == '0) ? CNT_W'(1) : dis_len_i;
  // leading-edge delay: ((max - lvl) * chg) / 2^SS_W
  assign prod    = {{SS_W{1'b0}}, chg_eff} * {{CNT_W{1'b0}}, SS_MAX - ss_lvl_i};
  assign dly_nxt = CNT_W'(prod >> SS_W);

  assign chg_last = (cnt_q == chg_q - 1'b1);
  assign dis_last = (cnt_q == dis_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      phase_q <= PH_CHG;
      cnt_q   <= '0;
      chg_q   <= CNT_W'(1);
      dis_q   <= CNT_W'(1);
      dly_q   <= '0;
      ss_q    <= '0;
    end else begin
      pend_q <= 1'b0;
      if (!en_i) begin
        run_q   <= 1'b0;
        phase_q <= PH_CHG;
        cnt_q   <= '0;
      end else if (!run_q || (phase_q == PH_DIS && dis_last)) begin
        run_q   <= 1'b1;
        pend_q  <= run_q;
        phase_q <= PH_CHG;
        cnt_q   <= '0;
        chg_q   <= chg_eff;
        dis_q   <= dis_eff;
        dly_q   <= dly_nxt;
        ss_q    <= ss_lvl_i;
      end else if (phase_q == PH_CHG && chg_last) begin
        phase_q <= PH_DIS;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_o   = run_q;
  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign dly_o   = dly_q;
  assign ss_on_o = (ss_q != '0);
  assign wrap_o  = run_q && (phase_q == PH_DIS) && dis_last;
  assign pend_o  = pend_q;
endmodule

// File: rtl/pp_steer.sv
module pp_steer
  import pp_gate_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic             ss_on_i,
  input  logic             wrap_i,
  input  logic             oc_i,
  output logic             gate_a_o,
  output logic             gate_b_o
);
  logic sel_q, on;

  // toggle: 0 selects A; back to A while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= 1'b0;
    else if (!run_i)  sel_q <= 1'b0;
    else if (wrap_i)  sel_q <= ~sel_q;
  end

  // oc_i blanks combinationally
  assign on = run_i && (phase_i == PH_CHG) && ss_on_i && (cnt_i >= dly_i) && !oc_i;

  assign gate_a_o = on && !sel_q;
  assign gate_b_o = on &&  sel_q;
endmodule

// File: rtl/pp_gate_seq.sv
module pp_gate_seq
  import pp_gate_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SS_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             oc_i,
  input  logic [SS_W-1:0]  ss_lvl_i,
  input  logic [CNT_W-1:0] chg_len_i,
  input  logic [CNT_W-1:0] dis_len_i,
  output logic             gate_a_o,
  output logic             gate_b_o,
  output logic             sync_o,
  output logic             period_end_o
);
  logic             run, ss_on, wrap;
  phase_e           phase;
  logic [CNT_W-1:0] cnt, dly;

  pp_period_ctr #(.CNT_W(CNT_W), .SS_W(SS_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .ss_lvl_i  (ss_lvl_i),
    .chg_len_i (chg_len_i),
    .dis_len_i (dis_len_i),
    .run_o     (run),
    .phase_o   (phase),
    .cnt_o     (cnt),
    .dly_o     (dly),
    .ss_on_o   (ss_on),
    .wrap_o    (wrap),
    .pend_o    (period_end_o)
  );

  pp_steer #(.CNT_W(CNT_W)) u_steer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .phase_i  (phase),
    .cnt_i    (cnt),
    .dly_i    (dly),
    .ss_on_i  (ss_on),
    .wrap_i   (wrap),
    .oc_i     (oc_i),
    .gate_a_o (gate_a_o),
    .gate_b_o (gate_b_o)
  );

  assign sync_o = run && (phase == PH_DIS);
endmodule

// File: rtl/pp_gate_seq_chk.sv
module pp_gate_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic oc_i,
  input logic gate_a_o,
  input logic gate_b_o,
  input logic sync_o,
  input logic period_end_o
);
  assert_no_overlap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_a_o && gate_b_o));

  assert_dead_time_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (!gate_a_o && !gate_b_o));

  assert_oc_blank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_i |-> (!gate_a_o && !gate_b_o));

  assert_disabled_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!gate_a_o && !gate_b_o && !sync_o && !period_end_o));

  assert_tick_after_sync_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |-> ($past(sync_o) && !sync_o));
endmodule

bind pp_gate_seq pp_gate_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .oc_i         (oc_i),
  .gate_a_o     (gate_a_o),
  .gate_b_o     (gate_b_o),
  .sync_o       (sync_o),
  .period_end_o (period_end_o)
);

// File: tb/pp_gate_seq_tb_top.sv
module pp_gate_seq_tb_top;
  localparam int CNT_W = 8;
  localparam int SS_W  = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0, oc = 1'b0;
  logic [SS_W-1:0]  ss = '0;
  logic [CNT_W-1:0] chg = 8'd1, dis = 8'd1;
  logic             ga, gb, sy, pe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string ov = "";

  // model state
  bit m_run = 0, m_pe = 0;
  int m_r = 0, m_p = 0, m_c = 1, m_d = 1, m_dl = 0, m_ss = 0;

  always #4 clk = ~clk;

  pp_gate_seq #(.CNT_W(CNT_W), .SS_W(SS_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .oc_i(oc), .ss_lvl_i(ss),
    .chg_len_i(chg), .dis_len_i(dis), .gate_a_o(ga), .gate_b_o(gb),
    .sync_o(sy), .period_end_o(pe));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b r=%0d p=%0d c=%0d d=%0d ss=%0d",
               tag, act, exp, m_r, m_p, m_c, m_d, m_ss);
    end
  endtask

  task automatic latch_model();
    m_c  = (chg == 0) ? 1 : int'(chg);
    m_d  = (dis == 0) ? 1 : int'(dis);
    m_ss = int'(ss);
    m_dl = ((7 - m_ss) * m_c) >> 3;
  endtask

  task automatic model_step();
    m_pe = 0;
    if (!en) m_run = 0;
    else if (!m_run) begin
      m_run = 1; m_r = 0; m_p = 0; latch_model();
    end else begin
      m_r++;
      if (m_r == m_c + m_d) begin
        m_r = 0; m_p++; m_pe = 1; latch_model();
      end
    end
  endtask

  task automatic compare();
    bit on;
    string ta, tb, ts;
    on = m_run && !oc && m_ss != 0 && m_r < m_c && m_r >= m_dl;
    ta = !m_run ? "R4" : (m_r >= m_c) ? "R2" : (m_ss == 0) ? "R6" : "R5";
    tb = !m_run ? "R4" : (m_r >= m_c) ? "R2" : (m_ss == 0) ? "R6" : "R1";
    ts = m_run ? "R3" : "R4";
    if (ov != "") begin ta = ov; tb = ov; ts = ov; end
    chk(ta, ga, on && (m_p % 2 == 0));
    chk(tb, gb, on && (m_p % 2 == 1));
    chk(ts, sy, m_run && m_r >= m_c);
    chk("R9", pe, m_pe);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    #1;
    compare();
  endtask

  initial begin
    #5000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R4)
    chk("R4", ga, 1'b0); chk("R4", gb, 1'b0); chk("R4", sy, 1'b0); chk("R4", pe, 1'b0);
    rst_n = 1'b1;
    cyc();

    // sweep lengths and levels; zero lengths exercise the R8 clamp
    for (int c = 0; c <= 4; c++)
      for (int d = 0; d <= 3; d++)
        for (int s = 0; s <= 7; s++) begin
          chg = CNT_W'(c); dis = CNT_W'(d); ss = SS_W'(s);
          ov = (c == 0 || d == 0) ? "R8" : "";
          en = 1'b1;
          for (int k = 0; k < 3 * ((c == 0 ? 1 : c) + (d == 0 ? 1 : d)) + 1; k++) cyc();
          en = 1'b0;
          ov = "";
          cyc(); cyc();
        end

    // R8: mid-period length and level change applies next period
    chg = 8'd4; dis = 8'd2; ss = 3'd7; en = 1'b1;
    ov = "R8";
    cyc(); cyc();
    chg = 8'd2; dis = 8'd1; ss = 3'd4;
    for (int k = 0; k < 14; k++) cyc();
    en = 1'b0; cyc(); cyc();
    ov = "";

    // R7: over-current blanks gates in the same cycle
    chg = 8'd6; dis = 8'd2; ss = 3'd7; en = 1'b1;
    cyc(); cyc();
    oc = 1'b1; #1;
    chk("R7", ga, 1'b0); chk("R7", gb, 1'b0);
    cyc(); cyc();
    oc = 1'b0; #1;
    chk("R7", ga, 1'b1);
    for (int k = 0; k < 12; k++) cyc();
    en = 1'b0; cyc(); cyc();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule